// File: doc/BRIEF.md
# Double-Buffered NCO Phase Front End

This block is the processor-facing write port and phase accumulator of a numerically controlled oscillator. A host writes bytes over an 8-bit bus with a 4-bit address. The bytes are captured on a write strobe clock that has no fixed relation to the oscillator clock, and they land in staging registers. Two 32-bit frequency words are staged: a center word and an offset word. Each word is written as four bytes.

An active-low update input moves both staged words into the active copies in one step. The update is carried into the oscillator clock domain, so a frequency word never changes one byte at a time. On every oscillator clock edge the accumulator adds either the center word alone or the sum of the center and offset words. An offset-select input makes that choice. The accumulator wraps modulo 2^32, and its upper bits leave the block as the phase word. They pass through a fixed delay, so that the latency from reset and from offset-select matches a fixed pipeline.

The reset input is qualified by the update input. It acts only while the update input is held low. It clears the active words and the accumulator. It leaves the staging registers untouched.

Top module: `nco_ctrl_front`

## Requirements
- R1: On a rising edge of `wr_clk` with `we_n` low, the byte on `wr_data` is stored at `wr_addr`. Addresses 0 to 3 hold the center word and addresses 4 to 7 hold the offset word, with the lower address holding the less significant byte. Writes to addresses 8 to 15 change nothing.
- R2: On a rising edge of `wr_clk` with `we_n` high, no staged byte changes.
- R3: Staged bytes have no effect on the phase until `upd_n` goes from high to low. Let edge c be the first `nco_clk` edge that samples `upd_n` low. The active words are loaded at edge c+2. The first accumulation using them happens at edge c+3, and it appears at `phase_o` after edge c+14.
- R4: While `upd_n` stays low, the active words are loaded only once. Bytes staged during that time take effect only at the next high-to-low transition.
- R5: Each `nco_clk` edge adds the active center word to the accumulator, plus the active offset word when the offset path is selected. The sum is taken modulo 2^32.
- R6: After edge j, `phase_o` equals the upper 16 bits of the accumulator value that it held after edge j-11.
- R7: Let edge c be the first edge that samples a new level of `ofs_en`. That edge is counted as the first. The first phase sample that uses the new increment appears at `phase_o` after the 14th edge (c+13).
- R8: When `rst` is high and `upd_n` is low at an `nco_clk` edge, the active words and the accumulator become zero. If the last such edge is r-1, `phase_o` still shows earlier samples after edge r+9 and shows zero from edge r+10 on.
- R9: When `rst` is high while `upd_n` is high, accumulation continues unchanged.
- R10: After reset, and until an update loads nonzero words, `phase_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| nco_clk | input | 1 | Oscillator clock for the accumulator and the phase output |
| rst | input | 1 | Active-high synchronous reset, which acts only while upd_n is low |
| wr_clk | input | 1 | Host write strobe clock |
| we_n | input | 1 | Active-low write enable |
| wr_addr | input | 4 | Staging register address |
| wr_data | input | 8 | Write byte, bit 7 most significant |
| upd_n | input | 1 | Active-low update, which transfers staged words to active words on assertion |
| ofs_en | input | 1 | Selects center plus offset (1) or center only (0) |
| phase_o | output | 16 | Upper accumulator bits, delayed |

## Verification
The hardest case to reach is the one where `upd_n` is held low while new bytes are staged. A level-sensitive design would pick those bytes up, and the output would show no sign of the error unless the increment is measured afterwards. The stimulus loads center words that are whole multiples of 2^16. The step between consecutive phase samples then equals an exact small integer, and the bench can read which word is active from two adjacent outputs. The reset latency needs a reset pulse of exactly one edge, so that the last pre-reset sample is still in flight when the zero arrives. The offset latency is measured from the exact edge that first samples the new `ofs_en` level.

// File: rtl/nco_cfg_pkg.sv
package nco_cfg_pkg;

  typedef enum logic [1:0] {
    RGN_CENTER = 2'd0,
    RGN_OFFSET = 2'd1,
    RGN_NONE   = 2'd2
  } rgn_e;

  // Map a byte address onto the staged word it belongs to.
  function automatic rgn_e addr_region(input int unsigned a, input int unsigned lanes);
    if (a < lanes)          return RGN_CENTER;
    else if (a < 2 * lanes) return RGN_OFFSET;
    return RGN_NONE;
  endfunction

endpackage

// File: rtl/nco_wr_stage.sv
module nco_wr_stage
  import nco_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int FREQ_W = 32
) (
  input  logic              wr_clk,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FREQ_W-1:0] cen_stg,
  output logic [FREQ_W-1:0] ofs_stg
);
  localparam int LANES = FREQ_W / DATA_W;
  localparam int IDX_W = $clog2(2 * LANES);

  logic [DATA_W-1:0] stg_mem [2*LANES];
  logic              wr_hit;

  assign wr_hit = !we_n && (addr_region(int'(wr_addr), LANES) != RGN_NONE);

  // Register file in the write domain; no reset so it maps to distributed RAM.
  always_ff @(posedge wr_clk) begin
    if (wr_hit) stg_mem[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cen_stg[g*DATA_W +: DATA_W] = stg_mem[g];
    assign ofs_stg[g*DATA_W +: DATA_W] = stg_mem[LANES+g];
  end

endmodule

// File: rtl/nco_upd_sync.sv
module nco_upd_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int OFS_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_n,
  input  logic ofs_en,
  output logic load,
  output logic ofs_sel
);
  logic [SYNC_STAGES-1:0] upd_s;
  logic                   upd_prev;
  logic [OFS_STAGES-1:0]  ofs_s;

  // Reset parks the chain at "asserted" so a low upd_n after reset is no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_s    <= '0;
      upd_prev <= 1'b0;
    end else begin
      upd_s[0] <= upd_n;
      for (int i = 1; i < SYNC_STAGES; i++) upd_s[i] <= upd_s[i-1];
      upd_prev <= upd_s[SYNC_STAGES-1];
    end
  end

  assign load = upd_prev & ~upd_s[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    ofs_s[0] <= ofs_en;
    for (int i = 1; i < OFS_STAGES; i++) ofs_s[i] <= ofs_s[i-1];
  end

  assign ofs_sel = ofs_s[OFS_STAGES-1];

  // R4: one assertion of upd_n gives one load pulse only
  assert_single_load_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int OUT_LAT = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               ofs_sel,
  input  logic [FREQ_W-1:0]  cen_stg,
  input  logic [FREQ_W-1:0]  ofs_stg,
  output logic [FREQ_W-1:0]  cen_act,
  output logic [FREQ_W-1:0]  ofs_act,
  output logic [FREQ_W-1:0]  acc_q,
  output logic [PHASE_W-1:0] phase_o
);
  logic [FREQ_W-1:0]  step;
  logic [PHASE_W-1:0] dly [OUT_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cen_act <= '0;
      ofs_act <= '0;
    end else if (load) begin
      cen_act <= cen_stg;
      ofs_act <= ofs_stg;
    end
  end

  assign step = ofs_sel ? (cen_act + ofs_act) : cen_act;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + step;
  end

  // Shift-register delay line without reset so it packs into LUT shifters.
  always_ff @(posedge clk) begin
    dly[0] <= acc_q[FREQ_W-1 -: PHASE_W];
    for (int i = 1; i < OUT_LAT; i++) dly[i] <= dly[i-1];
  end

  assign phase_o = dly[OUT_LAT-1];

endmodule

// File: rtl/nco_ctrl_front.sv
module nco_ctrl_front #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int FREQ_W      = 32,
  parameter int PHASE_W     = 16,
  parameter int OUT_LAT     = 11,
  parameter int OFS_LAT     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic               nco_clk,
  input  logic               rst,
  input  logic               wr_clk,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               upd_n,
  input  logic               ofs_en,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int OFS_STAGES = OFS_LAT - OUT_LAT - 1;

  logic              rst_eff;
  logic              load;
  logic              ofs_sel;
  logic [FREQ_W-1:0] cen_stg, ofs_stg, cen_act, ofs_act, acc_q;
  logic              ever_rst = 1'b0;

  assign rst_eff = rst & ~upd_n;

  nco_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FREQ_W(FREQ_W)) u_stage (
    .wr_clk (wr_clk),
    .we_n   (we_n),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .cen_stg(cen_stg),
    .ofs_stg(ofs_stg)
  );

  nco_upd_sync #(.SYNC_STAGES(SYNC_STAGES), .OFS_STAGES(OFS_STAGES)) u_sync (
    .clk    (nco_clk),
    .rst    (rst_eff),
    .upd_n  (upd_n),
    .ofs_en (ofs_en),
    .load   (load),
    .ofs_sel(ofs_sel)
  );

  nco_phase_acc #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .OUT_LAT(OUT_LAT)) u_acc (
    .clk    (nco_clk),
    .rst    (rst_eff),
    .load   (load),
    .ofs_sel(ofs_sel),
    .cen_stg(cen_stg),
    .ofs_stg(ofs_stg),
    .cen_act(cen_act),
    .ofs_act(ofs_act),
    .acc_q  (acc_q),
    .phase_o(phase_o)
  );

  always_ff @(posedge nco_clk) begin
    if (rst_eff) ever_rst <= 1'b1;
  end

  // R3: active words move only on a load pulse or a reset
  assert_active_change_R3: assert property (@(posedge nco_clk) disable iff (!ever_rst)
    !$stable(cen_act) |-> ($past(load) || $past(rst_eff)));

  // R8: qualified reset leaves accumulator and active words at zero
  assert_rst_clear_R8: assert property (@(posedge nco_clk) disable iff (!ever_rst)
    rst_eff |=> (acc_q == '0 && cen_act == '0 && ofs_act == '0));

  // R9: reset with update high keeps accumulating
  assert_rst_gated_R9: assert property (@(posedge nco_clk) disable iff (!ever_rst || rst_eff)
    (rst && upd_n) |=> acc_q == $past(acc_q) + $past(cen_act) + ($past(ofs_sel) ? $past(ofs_act) : '0));

endmodule

// File: tb/tb_nco_ctrl_front.sv
`timescale 1ns/1ps
module tb_nco_ctrl_front;
  logic        nco_clk = 1'b0;
  logic        wr_clk  = 1'b0;
  logic        rst     = 1'b1;
  logic        we_n    = 1'b1;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        upd_n   = 1'b0;
  logic        ofs_en  = 1'b0;
  logic [15:0] phase_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;
  string cur_req = "R6";

  always #2   nco_clk = ~nco_clk;
  always #3.5 wr_clk  = ~wr_clk;

  nco_ctrl_front dut (
    .nco_clk(nco_clk), .rst(rst), .wr_clk(wr_clk), .we_n(we_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd_n(upd_n), .ofs_en(ofs_en),
    .phase_o(phase_o)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_stg [8];
  logic [31:0] m_acc = '0, m_cen = '0, m_ofs = '0;
  logic [15:0] m_out [12];
  bit u1 = 0, u2 = 0, u3 = 0, o1 = 0, o2 = 0;

  initial for (int i = 0; i < 12; i++) m_out[i] = '0;
  initial for (int i = 0; i < 8; i++) m_stg[i] = '0;

  always @(posedge wr_clk) begin
    if (!we_n && wr_addr < 4'd8) m_stg[wr_addr[2:0]] = wr_data;
  end

  always @(posedge nco_clk) begin
    bit rn, ld;
    logic [31:0] nacc;
    rn = rst && !upd_n;
    ld = !u2 && u3;
    nacc = rn ? 32'd0 : (m_acc + m_cen + (o2 ? m_ofs : 32'd0));
    if (rn) begin
      m_cen = '0; m_ofs = '0;
    end else if (ld) begin
      m_cen = {m_stg[3], m_stg[2], m_stg[1], m_stg[0]};
      m_ofs = {m_stg[7], m_stg[6], m_stg[5], m_stg[4]};
    end
    m_acc = nacc;
    for (int i = 11; i > 0; i--) m_out[i] = m_out[i-1];
    m_out[0] = m_acc[31:16];
    u3 = u2; u2 = u1; u1 = upd_n;
    o2 = o1; o1 = ofs_en;
  end

  // R6: cycle-by-cycle comparison against the model
  always @(negedge nco_clk) begin
    if (cmp_en) begin
      n_tests++;
      if (phase_o !== m_out[11]) begin
        n_fail++;
        $display("FAIL %s model compare: phase_o=%h expected=%h at %0t", cur_req, phase_o, m_out[11], $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge nco_clk);
    @(negedge nco_clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [3:0] a, input logic [7:0] d, input bit en);
    @(negedge wr_clk);
    wr_addr = a; wr_data = d; we_n = !en;
    @(negedge wr_clk);
    we_n = 1'b1;
  endtask

  task automatic wr_word(input logic [3:0] base, input logic [31:0] w);
    for (int k = 0; k < 4; k++) wr_byte(base + 4'(k), w[k*8 +: 8], 1'b1);
  endtask

  task automatic pulse_upd();
    upd_n = 1'b0; step(6);
    upd_n = 1'b1; step(20);
  endtask

  function automatic logic [15:0] get_diff_dummy(input logic [15:0] a);
    return a;
  endfunction

  task automatic diff_chk(input string req, input logic [15:0] exp);
    logic [15:0] a, b;
    a = phase_o; step(1); b = phase_o;
    chk((b - a) == exp, req, b - a, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge nco_clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] a, b, d;
    @(negedge nco_clk);
    step(20);
    rst = 1'b0;
    step(3);
    cmp_en = 1'b1;
    upd_n = 1'b1;
    step(10);
    cur_req = "R10";
    chk(phase_o == 16'h0, "R10 reset state", phase_o, 16'h0);

    // R1/R2: stage words, an ignored address and a write with we_n high
    cur_req = "R1";
    wr_word(4'd0, 32'h0123_4567);
    wr_word(4'd4, 32'h0010_0000);
    wr_byte(4'd2, 8'hFF, 1'b0);   // R2: we_n high
    wr_byte(4'd10, 8'hEE, 1'b1);  // R1: address outside both words
    step(20);
    cur_req = "R3";
    chk(phase_o == 16'h0, "R3 staged bytes inert before update", phase_o, 16'h0);

    // R3: exact update latency; R1/R2 value of the loaded word
    upd_n = 1'b0;
    step(14);
    chk(phase_o == 16'h0, "R3 output before latency", phase_o, 16'h0);
    step(1);
    chk(phase_o == 16'h0123, "R3 R1 R2 first sample uses loaded center", phase_o, 16'h0123);
    step(5);
    upd_n = 1'b1;
    step(20);

    // R5: exact step with a center of whole 2^16 units
    cur_req = "R5";
    wr_word(4'd0, 32'h0001_0000);
    step(5);
    pulse_upd();
    diff_chk("R5 center-only step", 16'h0001);

    // R7: offset select latency
    cur_req = "R7";
    ofs_en = 1'b1;
    step(12); a = phase_o;
    step(1);  b = phase_o;
    step(1);  d = phase_o;
    chk((b - a) == 16'h0001, "R7 old increment through edge 13", b - a, 16'h0001);
    chk((d - b) == 16'h0011, "R7 new increment at edge 14", d - b, 16'h0011);
    diff_chk("R5 center plus offset step", 16'h0011);
    ofs_en = 1'b0;
    step(20);

    // R4: update held low, new bytes staged meanwhile
    cur_req = "R4";
    upd_n = 1'b0;
    step(6);
    wr_word(4'd0, 32'h0002_0000);
    step(20);
    diff_chk("R4 no reload while held low", 16'h0001);
    upd_n = 1'b1; step(6);
    upd_n = 1'b0; step(20);
    diff_chk("R4 reload on next assertion", 16'h0002);
    upd_n = 1'b1; step(20);

    // R5: wrap modulo 2^32
    cur_req = "R5";
    wr_word(4'd0, 32'hFFFF_0000);
    step(5);
    pulse_upd();
    diff_chk("R5 wrap step", 16'hFFFF);

    // R9: reset while update is high does nothing
    cur_req = "R9";
    rst = 1'b1;
    step(5);
    diff_chk("R9 reset ignored during run", 16'hFFFF);
    rst = 1'b0;
    step(14);
    diff_chk("R9 step unchanged after", 16'hFFFF);

    // R8: one-edge qualified reset
    cur_req = "R8";
    upd_n = 1'b0;
    step(6);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    step(10);
    chk(phase_o == m_out[11], "R8 earlier sample still in flight", phase_o, m_out[11]);
    step(1);
    chk(phase_o == 16'h0, "R8 zero at edge r+10", phase_o, 16'h0);
    step(20);
    chk(phase_o == 16'h0, "R8 R10 stays zero after reset", phase_o, 16'h0);
    upd_n = 1'b1;
    step(20);
    chk(phase_o == 16'h0, "R10 zero until next update", phase_o, 16'h0);

    cmp_en = 1'b0;
    step(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule